// File: doc/BRIEF.md
# Branch Condition and Next-PC Resolver

This block resolves one control-transfer instruction per request for an 8-bit processor core. On each request it receives the opcode, the current program counter and stack pointer, a 16-bit target operand, the HL pair, the word sitting on top of the stack, and the zero, carry, parity, sign and overflow flags. From these it decides whether the transfer is taken.

It covers jumps, calls and returns, both conditional and unconditional. It also covers jump through HL, the eight fixed-vector restarts, and a restart that fires only on overflow. For each request it reports:
- the next program counter;
- the stack pointer after the instruction;
- whether a return address must be pushed, with the byte addresses it occupies;
- whether a word was consumed from the stack;
- the number of machine clock cycles the instruction used.

Stack memory is not part of the block. The caller supplies the top-of-stack word with the request and performs any write that is reported.

All results are registered. They appear one clock after `req_valid` and are marked by a single-cycle `res_valid` pulse. An opcode that is not a control transfer is reported with `res_ctl` low.

Top module: `branch_resolver`

## Requirements
- R1: After synchronous reset, `res_valid`, `res_push`, `res_pop`, `res_taken` and `res_ctl` are 0 and `res_pc` is 0000h.
- R2: Conditional opcodes select their test with opcode bits 5:3. The codes are 0 zero clear, 1 zero set, 2 carry clear, 3 carry set, 4 parity clear, 5 parity set, 6 sign clear and 7 sign set.
- R3: A conditional jump (opcode 11ccc010) that is taken loads the target and takes 10 cycles. When not taken it advances the PC by 3 and takes 7 cycles. It never pushes or pops.
- R4: A call pushes PC+3 and lowers SP by 2. This applies to a taken conditional call (11ccc100, 18 cycles) and to the unconditional call CDh (18 cycles). The high byte goes to SP−1 and the low byte to SP−2, and the PC becomes the target. An untaken conditional call advances the PC by 3 in 9 cycles without pushing.
- R5: A return pops the top word into the PC and raises SP by 2. This applies to a taken conditional return (11ccc000, 12 cycles) and to the unconditional return C9h (10 cycles). An untaken conditional return advances the PC by 1 in 6 cycles without popping.
- R6: A restart (11nnn111) pushes PC+1, lowers SP by 2, jumps to n×8 and takes 12 cycles.
- R7: The overflow restart CBh behaves like a restart to 0040h (12 cycles) when the overflow flag is 1. Otherwise it advances the PC by 1 in 6 cycles with no push.
- R8: Jump through HL (E9h) loads the PC from HL, leaves SP unchanged and takes 6 cycles.
- R9: The unconditional jump C3h loads the target in 10 cycles whatever the flags.
- R10: Stack pointer and stack address arithmetic wraps modulo 65536.
- R11: Any other opcode gives `res_ctl`=0, `res_taken`=0, no push, no pop, PC and SP unchanged and 0 cycles.
- R12: `res_valid` is high exactly in the cycle after a cycle with `req_valid` high, and a push and a pop are never reported together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| opcode | input | 8 | Instruction opcode |
| cur_pc | input | 16 | Address of the instruction |
| cur_sp | input | 16 | Current stack pointer |
| operand | input | 16 | Jump or call target |
| hl | input | 16 | HL register pair |
| pop_word | input | 16 | Word at the top of the stack |
| flag_zero | input | 1 | Zero flag |
| flag_carry | input | 1 | Carry flag |
| flag_parity | input | 1 | Parity flag (1 = even) |
| flag_sign | input | 1 | Sign flag (1 = minus) |
| flag_ovf | input | 1 | Overflow flag |
| res_valid | output | 1 | Result strobe |
| res_ctl | output | 1 | Opcode was a control transfer |
| res_taken | output | 1 | Transfer taken |
| res_pc | output | 16 | Next program counter |
| res_sp | output | 16 | Stack pointer after the instruction |
| res_push | output | 1 | Return address must be written |
| res_push_word | output | 16 | Return address to write |
| res_push_hi_addr | output | 16 | Address of the high byte (SP−1) |
| res_push_lo_addr | output | 16 | Address of the low byte (SP−2) |
| res_pop | output | 1 | Top-of-stack word consumed |
| res_cycles | output | 5 | Machine cycles used |

## Verification
The bench walks all eight condition codes for jumps, calls and returns, with each flag driven both ways. A design with the condition order permuted, or with a polarity inverted, would then branch on the wrong flag state. Untaken paths are checked for the exact PC step and the short cycle count. A resolver that used the same step for every kind would land mid-instruction, and one with swapped cycle counts would mistime the core.

The overflow restart is tried with the flag both set and clear. A push at stack pointer 0001h and a pop at FFFFh expose missing wraparound. Non-control opcodes, including CBh's neighbours, confirm that nothing is pushed or popped when it should not be.

// File: rtl/brc_pkg.sv
package brc_pkg;

  localparam int CYC_W = 5;

  typedef enum logic [3:0] {
    K_NONE,
    K_JCC,
    K_JMP,
    K_CCC,
    K_CALL,
    K_RCC,
    K_RET,
    K_RST,
    K_RSTV,
    K_PCHL
  } kind_t;

  localparam logic [7:0] OP_JMP  = 8'hC3;
  localparam logic [7:0] OP_CALL = 8'hCD;
  localparam logic [7:0] OP_RET  = 8'hC9;
  localparam logic [7:0] OP_PCHL = 8'hE9;
  localparam logic [7:0] OP_RSTV = 8'hCB;

  localparam logic [CYC_W-1:0] CY_JCC_N  = 5'd7;
  localparam logic [CYC_W-1:0] CY_JCC_T  = 5'd10;
  localparam logic [CYC_W-1:0] CY_JMP    = 5'd10;
  localparam logic [CYC_W-1:0] CY_CCC_N  = 5'd9;
  localparam logic [CYC_W-1:0] CY_CCC_T  = 5'd18;
  localparam logic [CYC_W-1:0] CY_CALL   = 5'd18;
  localparam logic [CYC_W-1:0] CY_RCC_N  = 5'd6;
  localparam logic [CYC_W-1:0] CY_RCC_T  = 5'd12;
  localparam logic [CYC_W-1:0] CY_RET    = 5'd10;
  localparam logic [CYC_W-1:0] CY_RST    = 5'd12;
  localparam logic [CYC_W-1:0] CY_RSTV_N = 5'd6;
  localparam logic [CYC_W-1:0] CY_PCHL   = 5'd6;

endpackage

// File: rtl/brc_decode.sv
module brc_decode
  import brc_pkg::*;
(
  input  logic [7:0] op,
  output kind_t      kind,
  output logic [2:0] sel
);

  assign sel = op[5:3];

  always_comb begin
    kind = K_NONE;
    if (op[7:6] == 2'b11) begin
      unique case (op[2:0])
        3'b000: kind = K_RCC;
        3'b001: begin
          if (op == OP_RET)       kind = K_RET;
          else if (op == OP_PCHL) kind = K_PCHL;
        end
        3'b010: kind = K_JCC;
        3'b011: begin
          if (op == OP_JMP)       kind = K_JMP;
          else if (op == OP_RSTV) kind = K_RSTV;
        end
        3'b100: kind = K_CCC;
        3'b101: if (op == OP_CALL) kind = K_CALL;
        3'b111: kind = K_RST;
        default: kind = K_NONE;
      endcase
    end
  end

endmodule

// File: rtl/brc_cond.sv
module brc_cond #(
  parameter int NCOND = 8
) (
  input  logic [2:0] sel,
  input  logic       fz,
  input  logic       fc,
  input  logic       fp,
  input  logic       fs,
  output logic       met
);

  logic [3:0]       fv;
  logic [NCOND-1:0] tv;

  // Pairs of codes share one flag; the odd code tests it set, the even code clear.
  assign fv = {fs, fp, fc, fz};

  for (genvar g = 0; g < NCOND; g++) begin : g_test
    if (g % 2 == 1) begin : g_set
      assign tv[g] = fv[g/2];
    end else begin : g_clr
      assign tv[g] = ~fv[g/2];
    end
  end

  assign met = tv[sel];

endmodule

// File: rtl/brc_next.sv
module brc_next
  import brc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int RST_STRIDE = 8,
  parameter int OVF_VEC    = 64
) (
  input  kind_t              kind,
  input  logic               met,
  input  logic [2:0]         vec_idx,
  input  logic               ovf,
  input  logic [ADDR_W-1:0]  pc,
  input  logic [ADDR_W-1:0]  sp,
  input  logic [ADDR_W-1:0]  tgt,
  input  logic [ADDR_W-1:0]  hl,
  input  logic [ADDR_W-1:0]  top,
  output logic               ctl,
  output logic               taken,
  output logic [ADDR_W-1:0]  npc,
  output logic [ADDR_W-1:0]  nsp,
  output logic               push,
  output logic [ADDR_W-1:0]  push_word,
  output logic [ADDR_W-1:0]  push_hi,
  output logic [ADDR_W-1:0]  push_lo,
  output logic               pop,
  output logic [CYC_W-1:0]   cyc
);

  localparam logic [ADDR_W-1:0] STEP1   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] STEP2   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] STEP3   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] OVF_ADR = ADDR_W'(OVF_VEC);

  logic [ADDR_W-1:0] pc1, pc3, sp_dn, sp_up, rst_adr;

  assign pc1     = pc + STEP1;
  assign pc3     = pc + STEP3;
  assign sp_dn   = sp - STEP2;
  assign sp_up   = sp + STEP2;
  assign rst_adr = ADDR_W'(32'(vec_idx) * RST_STRIDE);

  assign push_hi = push ? sp - STEP1 : '0;
  assign push_lo = push ? sp_dn      : '0;

  always_comb begin
    ctl       = 1'b1;
    taken     = 1'b0;
    npc       = pc;
    nsp       = sp;
    push      = 1'b0;
    push_word = '0;
    pop       = 1'b0;
    cyc       = '0;
    unique case (kind)
      K_JCC: begin
        taken = met;
        npc   = met ? tgt : pc3;
        cyc   = met ? CY_JCC_T : CY_JCC_N;
      end
      K_JMP: begin
        taken = 1'b1;
        npc   = tgt;
        cyc   = CY_JMP;
      end
      K_CCC, K_CALL: begin
        taken = (kind == K_CALL) || met;
        if (taken) begin
          npc       = tgt;
          nsp       = sp_dn;
          push      = 1'b1;
          push_word = pc3;
          cyc       = (kind == K_CALL) ? CY_CALL : CY_CCC_T;
        end else begin
          npc = pc3;
          cyc = CY_CCC_N;
        end
      end
      K_RCC, K_RET: begin
        taken = (kind == K_RET) || met;
        if (taken) begin
          npc = top;
          nsp = sp_up;
          pop = 1'b1;
          cyc = (kind == K_RET) ? CY_RET : CY_RCC_T;
        end else begin
          npc = pc1;
          cyc = CY_RCC_N;
        end
      end
      K_RST, K_RSTV: begin
        taken = (kind == K_RST) || ovf;
        if (taken) begin
          npc       = (kind == K_RST) ? rst_adr : OVF_ADR;
          nsp       = sp_dn;
          push      = 1'b1;
          push_word = pc1;
          cyc       = CY_RST;
        end else begin
          npc = pc1;
          cyc = CY_RSTV_N;
        end
      end
      K_PCHL: begin
        taken = 1'b1;
        npc   = hl;
        cyc   = CY_PCHL;
      end
      default: ctl = 1'b0;
    endcase
  end

endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import brc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int RST_STRIDE = 8,
  parameter int OVF_VEC    = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [7:0]        opcode,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [ADDR_W-1:0] cur_sp,
  input  logic [ADDR_W-1:0] operand,
  input  logic [ADDR_W-1:0] hl,
  input  logic [ADDR_W-1:0] pop_word,
  input  logic              flag_zero,
  input  logic              flag_carry,
  input  logic              flag_parity,
  input  logic              flag_sign,
  input  logic              flag_ovf,
  output logic              res_valid,
  output logic              res_ctl,
  output logic              res_taken,
  output logic [ADDR_W-1:0] res_pc,
  output logic [ADDR_W-1:0] res_sp,
  output logic              res_push,
  output logic [ADDR_W-1:0] res_push_word,
  output logic [ADDR_W-1:0] res_push_hi_addr,
  output logic [ADDR_W-1:0] res_push_lo_addr,
  output logic              res_pop,
  output logic [CYC_W-1:0]  res_cycles
);

  kind_t             kind;
  logic [2:0]        sel;
  logic              met;
  logic              c_ctl, c_taken, c_push, c_pop;
  logic [ADDR_W-1:0] c_pc, c_sp, c_word, c_hi, c_lo;
  logic [CYC_W-1:0]  c_cyc;

  brc_decode u_dec (
    .op   (opcode),
    .kind (kind),
    .sel  (sel)
  );

  brc_cond #(.NCOND(8)) u_cond (
    .sel (sel),
    .fz  (flag_zero),
    .fc  (flag_carry),
    .fp  (flag_parity),
    .fs  (flag_sign),
    .met (met)
  );

  brc_next #(
    .ADDR_W     (ADDR_W),
    .RST_STRIDE (RST_STRIDE),
    .OVF_VEC    (OVF_VEC)
  ) u_next (
    .kind      (kind),
    .met       (met),
    .vec_idx   (sel),
    .ovf       (flag_ovf),
    .pc        (cur_pc),
    .sp        (cur_sp),
    .tgt       (operand),
    .hl        (hl),
    .top       (pop_word),
    .ctl       (c_ctl),
    .taken     (c_taken),
    .npc       (c_pc),
    .nsp       (c_sp),
    .push      (c_push),
    .push_word (c_word),
    .push_hi   (c_hi),
    .push_lo   (c_lo),
    .pop       (c_pop),
    .cyc       (c_cyc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid        <= 1'b0;
      res_ctl          <= 1'b0;
      res_taken        <= 1'b0;
      res_pc           <= '0;
      res_sp           <= '0;
      res_push         <= 1'b0;
      res_push_word    <= '0;
      res_push_hi_addr <= '0;
      res_push_lo_addr <= '0;
      res_pop          <= 1'b0;
      res_cycles       <= '0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_ctl          <= c_ctl;
        res_taken        <= c_taken;
        res_pc           <= c_pc;
        res_sp           <= c_sp;
        res_push         <= c_push;
        res_push_word    <= c_word;
        res_push_hi_addr <= c_hi;
        res_push_lo_addr <= c_lo;
        res_pop          <= c_pop;
        res_cycles       <= c_cyc;
      end else begin
        res_push <= 1'b0;
        res_pop  <= 1'b0;
      end
    end
  end

  // R12
  valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid == $past(req_valid));

  // R12
  push_pop_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({res_push, res_pop}));

  // R4
  push_sp_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_push |-> res_sp == $past(cur_sp) - ADDR_W'(2)
                              && res_push_hi_addr == $past(cur_sp) - ADDR_W'(1));

  // R5
  pop_pc_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_pop |-> res_pc == $past(pop_word)
                             && res_sp == $past(cur_sp) + ADDR_W'(2));

  // R8
  hl_jump_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid && $past(opcode) == OP_PCHL |-> res_pc == $past(hl) && res_taken);

  // R11
  nonctl_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid && !res_ctl |-> !res_taken && !res_push && !res_pop && res_cycles == '0);

endmodule

// File: tb/branch_resolver_tb.sv
`timescale 1ns/1ps
module branch_resolver_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [7:0]  opcode;
  logic [15:0] cur_pc, cur_sp, operand, hl, pop_word;
  logic        fz, fc, fp, fs, fv;
  logic        res_valid, res_ctl, res_taken, res_push, res_pop;
  logic [15:0] res_pc, res_sp, res_push_word, res_push_hi_addr, res_push_lo_addr;
  logic [4:0]  res_cycles;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  branch_resolver dut_i (
    .clk (clk), .rst (rst), .req_valid (req_valid), .opcode (opcode),
    .cur_pc (cur_pc), .cur_sp (cur_sp), .operand (operand), .hl (hl),
    .pop_word (pop_word), .flag_zero (fz), .flag_carry (fc),
    .flag_parity (fp), .flag_sign (fs), .flag_ovf (fv),
    .res_valid (res_valid), .res_ctl (res_ctl), .res_taken (res_taken),
    .res_pc (res_pc), .res_sp (res_sp), .res_push (res_push),
    .res_push_word (res_push_word), .res_push_hi_addr (res_push_hi_addr),
    .res_push_lo_addr (res_push_lo_addr), .res_pop (res_pop),
    .res_cycles (res_cycles)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // Flags as {v,s,p,c,z}
  task automatic issue(input logic [7:0] op, input logic [15:0] pc, input logic [15:0] sp,
                       input logic [4:0] fl);
    @(negedge clk);
    opcode = op; cur_pc = pc; cur_sp = sp;
    {fv, fs, fp, fc, fz} = fl;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // R2: code k tests flag k/2 of {s,p,c,z}; odd codes want it set
  function automatic logic [4:0] flags_for(input int k, input bit want_met);
    logic [4:0] f;
    f = 5'b0;
    f[k/2] = want_met ? k[0] : ~k[0];
    return f;
  endfunction

  task automatic t_reset();
    chk("R1 valid", res_valid, 0);
    chk("R1 push", res_push, 0);
    chk("R1 pop", res_pop, 0);
    chk("R1 taken", res_taken, 0);
    chk("R1 ctl", res_ctl, 0);
    chk("R1 pc", res_pc, 16'h0000);
  endtask

  task automatic t_cond_jump();
    for (int k = 0; k < 8; k++) begin
      issue(8'hC2 | 8'(k << 3), 16'h1234, 16'h8000, flags_for(k, 1));
      chk($sformatf("R2 R3 jcc%0d taken", k), res_taken, 1);
      chk($sformatf("R3 jcc%0d pc", k), res_pc, 16'hABCD);
      chk($sformatf("R3 jcc%0d cyc", k), res_cycles, 10);
      issue(8'hC2 | 8'(k << 3), 16'h1234, 16'h8000, flags_for(k, 0));
      chk($sformatf("R2 R3 jcc%0d not", k), res_taken, 0);
      chk($sformatf("R3 jcc%0d pc3", k), res_pc, 16'h1237);
      chk($sformatf("R3 jcc%0d cyc7", k), res_cycles, 7);
      chk($sformatf("R3 jcc%0d nopush", k), {res_push, res_pop}, 0);
    end
  endtask

  task automatic t_call();
    for (int k = 0; k < 8; k++) begin
      issue(8'hC4 | 8'(k << 3), 16'h1234, 16'h8000, flags_for(k, 1));
      chk($sformatf("R2 R4 ccc%0d pc", k), res_pc, 16'hABCD);
      chk($sformatf("R4 ccc%0d sp", k), res_sp, 16'h7FFE);
      chk($sformatf("R4 ccc%0d push", k), res_push, 1);
      chk($sformatf("R4 ccc%0d word", k), res_push_word, 16'h1237);
      chk($sformatf("R4 ccc%0d cyc", k), res_cycles, 18);
      issue(8'hC4 | 8'(k << 3), 16'h1234, 16'h8000, flags_for(k, 0));
      chk($sformatf("R4 ccc%0d not pc", k), res_pc, 16'h1237);
      chk($sformatf("R4 ccc%0d not push", k), res_push, 0);
      chk($sformatf("R4 ccc%0d not sp", k), res_sp, 16'h8000);
      chk($sformatf("R4 ccc%0d cyc9", k), res_cycles, 9);
    end
    issue(8'hCD, 16'h1234, 16'h8000, 5'b00000);
    chk("R4 call pc", res_pc, 16'hABCD);
    chk("R4 call hi", res_push_hi_addr, 16'h7FFF);
    chk("R4 call lo", res_push_lo_addr, 16'h7FFE);
    chk("R4 call cyc", res_cycles, 18);
  endtask

  task automatic t_ret();
    for (int k = 0; k < 8; k++) begin
      issue(8'hC0 | 8'(k << 3), 16'h1234, 16'h8000, flags_for(k, 1));
      chk($sformatf("R2 R5 rcc%0d pc", k), res_pc, 16'h4321);
      chk($sformatf("R5 rcc%0d sp", k), res_sp, 16'h8002);
      chk($sformatf("R5 rcc%0d pop", k), res_pop, 1);
      chk($sformatf("R5 rcc%0d cyc", k), res_cycles, 12);
      issue(8'hC0 | 8'(k << 3), 16'h1234, 16'h8000, flags_for(k, 0));
      chk($sformatf("R5 rcc%0d not pc", k), res_pc, 16'h1235);
      chk($sformatf("R5 rcc%0d not pop", k), res_pop, 0);
      chk($sformatf("R5 rcc%0d cyc6", k), res_cycles, 6);
    end
    issue(8'hC9, 16'h1234, 16'h8000, 5'b11111);
    chk("R5 ret pc", res_pc, 16'h4321);
    chk("R5 ret cyc", res_cycles, 10);
  endtask

  task automatic t_rst();
    for (int n = 0; n < 8; n++) begin
      issue(8'hC7 | 8'(n << 3), 16'h1234, 16'h8000, 5'b00000);
      chk($sformatf("R6 rst%0d pc", n), res_pc, 32'(n * 8));
      chk($sformatf("R6 rst%0d word", n), res_push_word, 16'h1235);
      chk($sformatf("R6 rst%0d sp", n), res_sp, 16'h7FFE);
      chk($sformatf("R6 rst%0d cyc", n), res_cycles, 12);
    end
  endtask

  task automatic t_rstv();
    issue(8'hCB, 16'h1234, 16'h8000, 5'b10000);
    chk("R7 ovf pc", res_pc, 16'h0040);
    chk("R7 ovf push", res_push, 1);
    chk("R7 ovf word", res_push_word, 16'h1235);
    chk("R7 ovf cyc", res_cycles, 12);
    issue(8'hCB, 16'h1234, 16'h8000, 5'b01111);
    chk("R7 noovf pc", res_pc, 16'h1235);
    chk("R7 noovf push", res_push, 0);
    chk("R7 noovf sp", res_sp, 16'h8000);
    chk("R7 noovf cyc", res_cycles, 6);
  endtask

  task automatic t_pchl_jmp();
    issue(8'hE9, 16'h1234, 16'h8000, 5'b00000);
    chk("R8 pchl pc", res_pc, 16'h5A5A);
    chk("R8 pchl sp", res_sp, 16'h8000);
    chk("R8 pchl cyc", res_cycles, 6);
    issue(8'hC3, 16'h1234, 16'h8000, 5'b00000);
    chk("R9 jmp pc a", res_pc, 16'hABCD);
    issue(8'hC3, 16'h1234, 16'h8000, 5'b11111);
    chk("R9 jmp pc b", res_pc, 16'hABCD);
    chk("R9 jmp cyc", res_cycles, 10);
  endtask

  task automatic t_wrap();
    issue(8'hCD, 16'hFFFE, 16'h0001, 5'b00000);
    chk("R10 call sp", res_sp, 16'hFFFF);
    chk("R10 call hi", res_push_hi_addr, 16'h0000);
    chk("R10 call lo", res_push_lo_addr, 16'hFFFF);
    chk("R10 call word", res_push_word, 16'h0001);
    issue(8'hC9, 16'h1234, 16'hFFFF, 5'b00000);
    chk("R10 ret sp", res_sp, 16'h0001);
  endtask

  task automatic t_other();
    logic [7:0] ops [5] = '{8'h00, 8'h3E, 8'hC5, 8'hDD, 8'hD3};
    foreach (ops[i]) begin
      issue(ops[i], 16'h1234, 16'h8000, 5'b11111);
      chk($sformatf("R11 op%h ctl", ops[i]), res_ctl, 0);
      chk($sformatf("R11 op%h taken", ops[i]), res_taken, 0);
      chk($sformatf("R11 op%h pp", ops[i]), {res_push, res_pop}, 0);
      chk($sformatf("R11 op%h pc", ops[i]), res_pc, 16'h1234);
      chk($sformatf("R11 op%h sp", ops[i]), res_sp, 16'h8000);
      chk($sformatf("R11 op%h cyc", ops[i]), res_cycles, 0);
    end
  endtask

  task automatic t_latency();
    issue(8'hCD, 16'h1234, 16'h8000, 5'b00000);
    chk("R12 valid pulse", res_valid, 1);
    @(negedge clk);
    chk("R12 valid drop", res_valid, 0);
    chk("R12 push drop", res_push, 0);
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; opcode = 8'h00;
    cur_pc = '0; cur_sp = '0; operand = 16'hABCD; hl = 16'h5A5A; pop_word = 16'h4321;
    {fv, fs, fp, fc, fz} = 5'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_cond_jump();
    t_call();
    t_ret();
    t_rst();
    t_rstv();
    t_pchl_jmp();
    t_wrap();
    t_other();
    t_latency();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_tests++;
    n_fail++;
    $display("FAIL R12 watchdog expired got 0 exp 1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule